// File: doc/BRIEF.md
# Multiplexed-Address DRAM Cycle Sequencer

This block sits between a synchronous request stream and a one-bit-wide asynchronous DRAM. The DRAM takes its row and column on one shared address bus, strobed by active-low row and column strobes. Each request carries a 20-bit word address, a direction flag and one write bit. The block turns each request into a timed sequence of strobe edges, all held on registered outputs. Reads come back as a single bit with a one-cycle valid strobe. Results arrive in the order the requests were accepted.

Every analog limit is a nanosecond parameter. The block converts each limit to a whole number of clocks at the configured clock period, rounding up. After an access the row stays open. A following request to the same row then costs only a column strobe cycle. A request to another row, an empty request stream, or a row-active time close to its upper limit makes the block close the row and precharge.

The request side follows valid/ready rules. A request transfers on a clock edge where both `req_valid` and `req_ready` are high. While `req_valid` is high and `req_ready` is low, the producer must hold address, direction and data steady. `req_ready` may depend on `req_addr` while a row is open, because it is only offered when the address hits that row. The read result has no back-pressure: the consumer must take `rd_data` in the cycle `rd_valid` is high. Refresh scheduling and power-up initialisation cycles belong to the surrounding logic.

Top module: `dram_seq_top`

## Requirements
- R1: The row is request address bits [19:10] and the column is bits [9:0]. The row is on `dram_addr` when `dram_ras_n` falls, and the column is on `dram_addr` when `dram_cas_n` falls.
- R2: `dram_ras_n` stays high for at least the precharge time. Two falling edges of `dram_ras_n` are at least the random cycle time apart.
- R3: `dram_ras_n` stays low for at least the minimum row-active time and never longer than the page-mode maximum (`T_RASP_NS`). The block closes the row early enough to stay within that maximum.
- R4: `dram_cas_n` falls only while `dram_ras_n` is low, and no earlier than the row-to-column delay after it fell. The row address is held for at least the row hold time after `dram_ras_n` falls.
- R5: Each `dram_cas_n` low pulse lasts at least the column pulse width. Within one open row, the column strobe stays high for at least its precharge time, and successive falling edges are at least the page cycle time apart.
- R6: A write is an early write. `dram_we_n` is low before `dram_cas_n` falls and stays low, with `dram_din` steady, until `dram_cas_n` rises. `dram_we_n` changes only while `dram_cas_n` is high.
- R7: In a read, `dram_we_n` stays high while `dram_cas_n` is low. `dram_dout` is sampled only after all three access times have passed: from the row strobe, the column strobe and the column address. The sampled bit appears on `rd_data` with a one-cycle `rd_valid` pulse, in request order.
- R8: Each accepted request produces exactly one column strobe cycle, with the accepted address and direction.
- R9: A request to the currently open row, presented while the row is open, is served by a column cycle alone, with no new row strobe.
- R10: The row is closed when the next request targets a different row or when no request is pending.
- R11: During and right after reset, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, `rd_valid` is low and `req_ready` is high.
- R12: The column address on `dram_addr` does not change while `dram_cas_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 20 | Word address: row in upper half, column in lower half |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 1 | Bit to write |
| rd_valid | output | 1 | One-cycle strobe for a read result |
| rd_data | output | 1 | Read result bit |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_din | output | 1 | Data into the DRAM |
| dram_dout | input | 1 | Data out of the DRAM |

## Verification
Reads swept column-first over a small block of rows change row on every request, so each one must pay a full row cycle. The same block swept row-first must open each row only once. Comparing the two tells page reuse apart from needless closing. A long run of reads to one row has to be broken into several row openings by the row-active limit. An isolated request followed by silence shows that the row is closed when the stream runs dry. Writes and reads interleaved at the address corners check the row/column split, the early-write form and the read-after-write data. The bench's DRAM model drives the inverted bit until every access time has passed, so a capture one cycle early returns wrong data.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROWSET,
    ST_RAH,
    ST_COLSET,
    ST_CAS,
    ST_OPEN,
    ST_CLOSE
  } seq_state_e;

  // whole clocks covering a nanosecond limit, never below one
  function automatic int ns2cyc(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_seq_age.sv
module dram_seq_age #(
  parameter int MAXV = 16,
  parameter int W    = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  output logic [W-1:0] age
);

  // cycles a level has lasted, counted as of the current edge; saturates
  always_ff @(posedge clk) begin
    if (rst)                  age <= W'(MAXV);
    else if (restart)         age <= W'(1);
    else if (age < W'(MAXV))  age <= age + 1'b1;
  end

endmodule

// File: rtl/dram_seq_amux.sv
module dram_seq_amux #(
  parameter int A_W = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_row,
  input  logic           ld_col,
  input  logic [A_W-1:0] row_in,
  input  logic [A_W-1:0] col_in,
  output logic [A_W-1:0] bus_addr,
  output logic [A_W-1:0] open_row
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr <= '0;
      open_row <= '0;
    end else if (ld_row) begin
      bus_addr <= row_in;
      open_row <= row_in;
    end else if (ld_col) begin
      bus_addr <= col_in;
    end
  end

  // R1: a single cycle never asks for both halves
  p_one_half_r1: assert property (@(posedge clk) disable iff (rst)
    !(ld_row && ld_col));

endmodule

// File: rtl/dram_seq_rdcap.sv
module dram_seq_rdcap (
  input  logic clk,
  input  logic rst,
  input  logic cap,
  input  logic dout,
  output logic rd_valid,
  output logic rd_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= 1'b0;
    end else begin
      rd_valid <= cap;
      if (cap) rd_data <= dout;
    end
  end

  // R7: results are single-cycle pulses, never back to back
  p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/dram_seq_top.sv
module dram_seq_top
  import dram_seq_pkg::*;
#(
  parameter int A_W        = 10,
  parameter int CLK_PS     = 5000,
  parameter int T_RP_NS    = 50,
  parameter int T_RC_NS    = 130,
  parameter int T_RAS_NS   = 70,
  parameter int T_RASP_NS  = 100000,
  parameter int T_RCD_NS   = 20,
  parameter int T_RAH_NS   = 10,
  parameter int T_CAS_NS   = 20,
  parameter int T_CP_NS    = 10,
  parameter int T_PC_NS    = 50,
  parameter int T_CAH_NS   = 15,
  parameter int T_WCH_NS   = 15,
  parameter int T_DH_NS    = 15,
  parameter int T_CWL_NS   = 25,
  parameter int T_RAC_NS   = 70,
  parameter int T_CAC_NS   = 25,
  parameter int T_AA_NS    = 40,
  parameter int T_RSH_NS   = 25,
  parameter int T_CSH_NS   = 70
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2*A_W-1:0] req_addr,
  input  logic             req_write,
  input  logic             req_wdata,
  output logic             rd_valid,
  output logic             rd_data,
  output logic             dram_ras_n,
  output logic             dram_cas_n,
  output logic             dram_we_n,
  output logic [A_W-1:0]   dram_addr,
  output logic             dram_din,
  input  logic             dram_dout
);

  localparam int ADDR_W = 2 * A_W;

  localparam int C_RP   = ns2cyc(T_RP_NS,   CLK_PS);
  localparam int C_RC   = ns2cyc(T_RC_NS,   CLK_PS);
  localparam int C_RAS  = ns2cyc(T_RAS_NS,  CLK_PS);
  localparam int C_RASP = ns2cyc(T_RASP_NS, CLK_PS);
  localparam int C_RCD  = ns2cyc(T_RCD_NS,  CLK_PS);
  localparam int C_RAH  = ns2cyc(T_RAH_NS,  CLK_PS);
  localparam int C_CAS  = ns2cyc(T_CAS_NS,  CLK_PS);
  localparam int C_CP   = ns2cyc(T_CP_NS,   CLK_PS);
  localparam int C_PC   = ns2cyc(T_PC_NS,   CLK_PS);
  localparam int C_CAH  = ns2cyc(T_CAH_NS,  CLK_PS);
  localparam int C_WCH  = ns2cyc(T_WCH_NS,  CLK_PS);
  localparam int C_DH   = ns2cyc(T_DH_NS,   CLK_PS);
  localparam int C_CWL  = ns2cyc(T_CWL_NS,  CLK_PS);
  localparam int C_RAC  = ns2cyc(T_RAC_NS,  CLK_PS);
  localparam int C_CAC  = ns2cyc(T_CAC_NS,  CLK_PS);
  localparam int C_AA   = ns2cyc(T_AA_NS,   CLK_PS);
  localparam int C_RSH  = ns2cyc(T_RSH_NS,  CLK_PS);
  localparam int C_CSH  = ns2cyc(T_CSH_NS,  CLK_PS);

  // precharge long enough that a minimum-width row pulse still meets the cycle time
  localparam int C_PRE  = imax(C_RP, C_RC - C_RAS);
  // column strobe low time for each direction
  localparam int C_CASW = imax(imax(C_CAS, C_CAH), imax(imax(C_WCH, C_DH), C_CWL));
  localparam int C_CASR = imax(imax(C_CAS, C_CAH), C_CAC);
  localparam int C_RDR  = imax(C_RAC, C_CSH);
  // worst-case cycles from a page accept to the row strobe rising
  localparam int GUARD  = C_PC + C_CP + imax(C_CASR, C_AA) + C_CASW + C_RSH + 4;
  localparam int BUDGET = C_RASP - GUARD;

  localparam int AGE_MAX = C_RASP + 1;
  localparam int AGE_W   = $clog2(AGE_MAX + 1);
  localparam int N_AGE   = 4;
  localparam int AG_RAS  = 0;  // since row strobe last moved
  localparam int AG_CAS  = 1;  // since column strobe last moved
  localparam int AG_PC   = 2;  // since column strobe last fell
  localparam int AG_COL  = 3;  // since column address was loaded

  seq_state_e st_q, st_d;

  logic [N_AGE-1:0] age_restart;
  logic [AGE_W-1:0] age_q [N_AGE];
  int ras_age, cas_age, pc_age, col_age;

  logic [A_W-1:0] open_row;
  logic [A_W-1:0] req_row, req_col;
  logic [A_W-1:0] col_q, cur_col;
  logic           wr_q, wd_q, cur_wr, cur_wd;
  logic           hit, budget_ok, acc;
  logic           ras_fall, ras_rise, cas_fall, cas_rise;
  logic           ld_row, ld_col, cap, cas_done;

  generate
    for (genvar g = 0; g < N_AGE; g++) begin : g_age
      dram_seq_age #(.MAXV(AGE_MAX), .W(AGE_W)) u_age (
        .clk     (clk),
        .rst     (rst),
        .restart (age_restart[g]),
        .age     (age_q[g])
      );
    end
  endgenerate

  assign ras_age = int'(age_q[AG_RAS]);
  assign cas_age = int'(age_q[AG_CAS]);
  assign pc_age  = int'(age_q[AG_PC]);
  assign col_age = int'(age_q[AG_COL]);

  assign age_restart[AG_RAS] = ras_fall | ras_rise;
  assign age_restart[AG_CAS] = cas_fall | cas_rise;
  assign age_restart[AG_PC]  = cas_fall;
  assign age_restart[AG_COL] = ld_col;

  assign req_row = req_addr[ADDR_W-1:A_W];
  assign req_col = req_addr[A_W-1:0];

  // a page accept takes the column straight from the request
  assign cur_col = (st_q == ST_OPEN) ? req_col   : col_q;
  assign cur_wr  = (st_q == ST_OPEN) ? req_write : wr_q;
  assign cur_wd  = (st_q == ST_OPEN) ? req_wdata : wd_q;

  assign hit       = (open_row == req_row);
  assign budget_ok = (ras_age < BUDGET);
  assign req_ready = (st_q == ST_IDLE) || ((st_q == ST_OPEN) && hit && budget_ok);
  assign acc       = req_valid && req_ready;

  always_comb begin
    if (wr_q) cas_done = (cas_age >= C_CASW) && (ras_age >= C_CSH);
    else      cas_done = (cas_age >= C_CASR) && (ras_age >= C_RDR) && (col_age >= C_AA);
  end

  always_comb begin
    st_d     = st_q;
    ras_fall = 1'b0;
    ras_rise = 1'b0;
    cas_fall = 1'b0;
    cas_rise = 1'b0;
    ld_row   = 1'b0;
    ld_col   = 1'b0;
    cap      = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (acc) begin
          ld_row = 1'b1;
          st_d   = ST_ROWSET;
        end
      end
      ST_ROWSET: begin
        if (ras_age >= C_PRE) begin
          ras_fall = 1'b1;
          st_d     = ST_RAH;
        end
      end
      ST_RAH: begin
        if (ras_age >= C_RAH) begin
          ld_col = 1'b1;
          st_d   = ST_COLSET;
        end
      end
      ST_COLSET: begin
        if ((cas_age >= C_CP) && (pc_age >= C_PC) && (ras_age >= C_RCD)) begin
          cas_fall = 1'b1;
          st_d     = ST_CAS;
        end
      end
      ST_CAS: begin
        if (cas_done) begin
          cas_rise = 1'b1;
          cap      = !wr_q;
          st_d     = ST_OPEN;
        end
      end
      ST_OPEN: begin
        if (acc) begin
          ld_col = 1'b1;
          st_d   = ST_COLSET;
        end else begin
          st_d   = ST_CLOSE;
        end
      end
      ST_CLOSE: begin
        if ((ras_age >= C_RAS) && (pc_age >= C_RSH)) begin
          ras_rise = 1'b1;
          st_d     = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      dram_ras_n <= 1'b1;
      dram_cas_n <= 1'b1;
      dram_we_n  <= 1'b1;
      dram_din   <= 1'b0;
      col_q      <= '0;
      wr_q       <= 1'b0;
      wd_q       <= 1'b0;
    end else begin
      st_q <= st_d;
      if (acc) begin
        col_q <= req_col;
        wr_q  <= req_write;
        wd_q  <= req_wdata;
      end
      if (ld_col) begin
        dram_we_n <= !cur_wr;
        dram_din  <= cur_wd;
      end
      if (ras_fall) dram_ras_n <= 1'b0;
      if (ras_rise) dram_ras_n <= 1'b1;
      if (cas_fall) dram_cas_n <= 1'b0;
      if (cas_rise) begin
        dram_cas_n <= 1'b1;
        dram_we_n  <= 1'b1;
      end
    end
  end

  dram_seq_amux #(.A_W(A_W)) u_amux (
    .clk      (clk),
    .rst      (rst),
    .ld_row   (ld_row),
    .ld_col   (ld_col),
    .row_in   (req_row),
    .col_in   (cur_col),
    .bus_addr (dram_addr),
    .open_row (open_row)
  );

  dram_seq_rdcap u_rdcap (
    .clk      (clk),
    .rst      (rst),
    .cap      (cap),
    .dout     (dram_dout),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  // R11: strobes inactive out of reset
  p_reset_r11: assert property (@(posedge clk)
    $past(rst) |-> (dram_ras_n && dram_cas_n && dram_we_n && !rd_valid));

  // R4: the column strobe only moves low inside an active row
  p_cas_in_row_r4: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n |-> !dram_ras_n);

  // R4: the row address does not change at the row strobe edge
  p_row_edge_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> $stable(dram_addr));

  // R12: column address steady while the column strobe is low
  p_col_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr));

  // R6: write enable and write data steady while the column strobe is low
  p_we_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!dram_cas_n && $past(!dram_cas_n)) |-> ($stable(dram_we_n) && $stable(dram_din)));

  // R7: a result follows a read strobe that has just ended
  p_rd_source_r7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($rose(dram_cas_n) && $past(dram_we_n)));

  // R3: row never held past its page-mode limit
  p_ras_max_r3: assert property (@(posedge clk) disable iff (rst)
    !dram_ras_n |-> (ras_age <= C_RASP));

  // R3: minimum row-active width before rising
  p_ras_min_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_ras_n) |-> ($past(ras_age) >= C_RAS));

  // R2: precharge satisfied before the row strobe falls
  p_pre_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> ($past(ras_age) >= C_PRE));

endmodule

// File: tb/sim_dram_seq_top.sv
`timescale 1ns/1ps
module sim_dram_seq_top;

  localparam real T_RASP = 1000.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_wdata = 1'b0;
  logic        rd_valid, rd_data;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_din;
  logic [9:0]  dram_addr;
  logic        dram_dout = 1'b0;

  always #2.5 clk = ~clk;

  dram_seq_top #(.T_RASP_NS(1000)) u0 (
    .clk, .rst, .req_valid, .req_ready, .req_addr, .req_write, .req_wdata,
    .rd_valid, .rd_data, .dram_ras_n, .dram_cas_n, .dram_we_n, .dram_addr,
    .dram_din, .dram_dout
  );

  int n_chk = 0;
  int n_bad = 0;
  bit mon_en = 1'b0;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic bit init_bit(input int a);
    return a[0] ^ a[4] ^ a[13] ^ a[19];
  endfunction

  // DRAM model storage and bench shadow kept apart
  bit dmem [int];
  bit smem [int];

  function automatic bit dm_rd(input int a);
    return dmem.exists(a) ? dmem[a] : init_bit(a);
  endfunction
  function automatic bit sh_rd(input int a);
    return smem.exists(a) ? smem[a] : init_bit(a);
  endfunction

  int acc_a[$];
  bit acc_w[$];
  bit acc_d[$];
  bit exp_q[$];

  real t_rf = 0.0, t_rr = 0.0, t_cf = 0.0, t_cr = 0.0, t_col = 0.0;
  bit  rf_seen = 0, rr_seen = 0, first_cas = 1, col_moved = 0;
  logic [9:0] row_lat = '0, col_lat = '0;
  int rfalls = 0;

  always @(negedge dram_ras_n) if (mon_en) begin
    if (rr_seen) chk(($realtime - t_rr) >= 50.0, "R2 precharge", longint'($realtime - t_rr), 50);
    if (rf_seen) chk(($realtime - t_rf) >= 130.0, "R2 cycle", longint'($realtime - t_rf), 130);
    t_rf = $realtime; rf_seen = 1; first_cas = 1; col_moved = 0;
    row_lat = dram_addr;
    rfalls++;
  end

  always @(posedge dram_ras_n) if (mon_en && rf_seen) begin
    chk(($realtime - t_rf) >= 70.0, "R3 min low", longint'($realtime - t_rf), 70);
    chk(($realtime - t_rf) <= T_RASP, "R3 max low", longint'($realtime - t_rf), longint'(T_RASP));
    t_rr = $realtime; rr_seen = 1;
  end

  always @(dram_addr) if (mon_en && !dram_ras_n) begin
    if (!col_moved)
      chk(($realtime - t_rf) >= 10.0, "R4 row hold", longint'($realtime - t_rf), 10);
    col_moved = 1;
    t_col = $realtime;
  end

  always @(negedge dram_cas_n) if (mon_en) begin
    int a;
    chk(!dram_ras_n, "R4 cas inside ras", dram_ras_n, 0);
    chk(($realtime - t_rf) >= 20.0, "R4 rcd", longint'($realtime - t_rf), 20);
    if (!first_cas) begin
      chk(($realtime - t_cf) >= 50.0, "R5 page cycle", longint'($realtime - t_cf), 50);
      chk(($realtime - t_cr) >= 10.0, "R5 cas precharge", longint'($realtime - t_cr), 10);
    end
    first_cas = 0;
    t_cf = $realtime;
    col_lat = dram_addr;
    a = int'({row_lat, col_lat});
    if (acc_a.size() == 0) begin
      chk(1'b0, "R8 cas without accept", 1, 0);
    end else begin
      chk(a == acc_a[0], "R1 R8 strobed address", a, acc_a[0]);
      chk(dram_we_n == !acc_w[0], "R6 R7 direction at cas fall", dram_we_n, !acc_w[0]);
      if (acc_w[0]) chk(dram_din == acc_d[0], "R6 write data", dram_din, acc_d[0]);
      void'(acc_a.pop_front()); void'(acc_w.pop_front()); void'(acc_d.pop_front());
    end
    if (!dram_we_n) dmem[a] = dram_din;
  end

  always @(posedge dram_cas_n) if (mon_en) begin
    chk(($realtime - t_cf) >= 20.0, "R5 cas width", longint'($realtime - t_cf), 20);
    t_cr = $realtime;
  end

  // DRAM data out: wrong bit until all access times have elapsed at the next edge
  logic       p_cas_n = 1'b1, p_we_n = 1'b1, p_din = 1'b0;
  logic [9:0] p_addr = '0;
  always @(negedge clk) begin
    real tn;
    bit  v, ok;
    tn = $realtime + 2.5;
    if (!dram_ras_n && !dram_cas_n && dram_we_n) begin
      v  = dm_rd(int'({row_lat, col_lat}));
      ok = ((tn - t_rf) >= 70.0) && ((tn - t_cf) >= 25.0) && ((tn - t_col) >= 40.0);
      dram_dout <= ok ? v : ~v;
    end else begin
      dram_dout <= 1'b0;
    end
    if (mon_en && !p_cas_n && !dram_cas_n) begin
      chk(dram_addr == p_addr, "R12 column held", dram_addr, p_addr);
      chk(dram_we_n == p_we_n, "R6 R7 we held", dram_we_n, p_we_n);
      chk(dram_din == p_din, "R6 din held", dram_din, p_din);
    end
    p_cas_n = dram_cas_n; p_we_n = dram_we_n; p_din = dram_din; p_addr = dram_addr;
    if (mon_en && rd_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R7 unexpected result", 1, 0);
      else begin
        chk(rd_data == exp_q[0], "R7 read data", rd_data, exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
  end

  // called at a falling clock edge; returns at the falling edge after the transfer
  task automatic send(input int a, input bit w, input bit d);
    req_addr  = a[19:0];
    req_write = w;
    req_wdata = d;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    acc_a.push_back(a); acc_w.push_back(w); acc_d.push_back(d);
    if (w) smem[a] = d;
    else   exp_q.push_back(sh_rd(a));
    @(negedge clk);
  endtask

  task automatic drain();
    int quiet;
    req_valid = 1'b0;
    quiet = 0;
    while (quiet < 4) begin
      @(negedge clk);
      if (exp_q.size() == 0 && acc_a.size() == 0 && dram_ras_n) quiet++;
      else quiet = 0;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    int f0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R11 strobes idle",
        {dram_ras_n, dram_cas_n, dram_we_n}, 7);
    chk(!rd_valid, "R11 no result", rd_valid, 0);
    chk(req_ready, "R11 ready", req_ready, 1);
    mon_en = 1'b1;

    // column-first reads: every request changes row (R10)
    f0 = rfalls;
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 4; r++) send(r * 1024 + c, 1'b0, 1'b0);
    drain();
    chk(rfalls - f0 == 32, "R10 row change closes", rfalls - f0, 32);

    // row-first writes of inverted pattern: one opening per row (R9)
    f0 = rfalls;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 8; c++) send(r * 1024 + c, 1'b1, !init_bit(r * 1024 + c));
    drain();
    chk(rfalls - f0 == 4, "R9 write page reuse", rfalls - f0, 4);

    // row-first reads of the written data (R9, R7)
    f0 = rfalls;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 8; c++) send(r * 1024 + c, 1'b0, 1'b0);
    drain();
    chk(rfalls - f0 == 4, "R9 read page reuse", rfalls - f0, 4);

    // isolated request then silence: row closed, next same-row request reopens (R10)
    f0 = rfalls;
    send(7 * 1024 + 3, 1'b0, 1'b0);
    req_valid = 1'b0;
    repeat (60) @(negedge clk);
    chk(dram_ras_n, "R10 closed when empty", dram_ras_n, 1);
    send(7 * 1024 + 4, 1'b0, 1'b0);
    drain();
    chk(rfalls - f0 == 2, "R10 reopen after empty", rfalls - f0, 2);

    // long same-row stream split by the row-active limit (R3)
    f0 = rfalls;
    for (int i = 0; i < 40; i++) send(5 * 1024 + i, 1'b0, 1'b0);
    drain();
    chk((rfalls - f0) >= 2 && (rfalls - f0) <= 8, "R3 long page split", rfalls - f0, 3);

    // write/read interleave at the address corners in one row (R1, R6, R7, R9)
    f0 = rfalls;
    for (int i = 0; i < 4; i++) begin
      int a;
      a = 1023 * 1024 + ((i == 0) ? 1023 : (i == 1) ? 0 : (i == 2) ? 512 : 1);
      send(a, 1'b1, !init_bit(a));
      send(a, 1'b0, 1'b0);
    end
    drain();
    chk(rfalls - f0 == 1, "R9 mixed page", rfalls - f0, 1);

    // top column of row zero and bottom of the last row: row split (R1)
    send(1023, 1'b1, 1'b1);
    send(1023 * 1024, 1'b1, 1'b0);
    send(1023, 1'b0, 1'b0);
    send(1023 * 1024, 1'b0, 1'b0);
    drain();

    chk(acc_a.size() == 0 && exp_q.size() == 0, "R8 all requests served",
        acc_a.size() + exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule